// File: doc/BRIEF.md
# Prefixed Single-Bit Operation Unit

This block executes the second byte of a prefix-escaped 8-bit CPU instruction that works on one bit of one operand. The byte it is given picks one of three operations (test, clear or set), the bit position, and the operand. The operand is one of seven 8-bit registers or the byte in memory that the H:L register pair points to. The surrounding core fetches the prefix and the opcode byte, shows the block a snapshot of the register file and the current flags, and pulses `start`. The block then reads and writes memory through a simple request/accept port. It finishes with a one-cycle `done` that carries the register write-back, the flag update and the cycle cost of the instruction.

Opcode bytes below 0x40 belong to other instruction families. For these the block raises `unsupported` for one cycle and makes no access and no write. The instruction is always two bytes long, so the block never consumes a further byte. The internal cycle counter keeps `done` low until the full cost of the instruction has elapsed, even when memory answers at once.

Top module: `bitop_unit`

## Requirements
- R1: Opcode bits [7:6] pick the operation: 01 (0x40–0x7F) tests, 10 (0x80–0xBF) clears and 11 (0xC0–0xFF) sets the chosen bit.
- R2: Opcode bits [5:3] give the bit position (0 = LSB). Bits [2:0] give the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory byte at {H,L}, 7 A. Register n is read from `regs_in[8n+7:8n]`, and slot 6 is unused.
- R3: A test drives `flags_wr` high with `done`. The flags are `flags_out` = {Z, N, H, C} on bits [3:0]: Z is the inverse of the tested bit, N = 0, H = 1, and C repeats `flags_in[0]`.
- R4: A test writes neither the register nor memory.
- R5: A set or clear on a register pulses `reg_wr_en` with `done`, with `reg_wr_sel` set to the operand code and `reg_wr_data` set to the modified value. `flags_wr` stays low.
- R6: A memory operand makes exactly one read at {H,L}. A set or clear then makes exactly one write of the modified byte to the same address. A test makes no write.
- R7: `done` is high in the cycle that starts the given number of clock edges after the edge that accepted `start`. The count is 8 for a register operand, 12 for a memory test and 16 for a memory set or clear. `cycles` shows that cost while `done` is high.
- R8: When memory is slow, `done` comes one cycle after the edge that accepted the last access, if that is later than the cost in R7.
- R9: An opcode below 0x40 raises `unsupported` for one cycle after the accepting edge. It gives no `done`, no register write and no memory access.
- R10: A `start` while an instruction is in flight is ignored, and `done` is a single-cycle pulse.
- R11: A synchronous reset returns the block to idle and drops any request or instruction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin executing `opcode` |
| opcode | input | 8 | Second instruction byte |
| regs_in | input | 64 | Register snapshot, 8 bits per operand code |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory address ({H,L}) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Current request accepted at this edge |
| reg_wr_en | output | 1 | Register write-back strobe |
| reg_wr_sel | output | 3 | Register code to write |
| reg_wr_data | output | 8 | Register write-back value |
| flags_wr | output | 1 | Flag update strobe |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| cycles | output | 5 | Cost of the finished instruction |
| done | output | 1 | Instruction complete |
| unsupported | output | 1 | Opcode outside this group |

## Verification
The bench keeps the default costs of 8, 12 and 16 cycles and varies only the latency of its memory model. It uses 0 and 3 cycles of wait, where the cost counter decides when `done` arrives. It also uses 12 cycles, where the read and write handshakes last longer than the cost and R8 takes over. A long wait also leaves a request open long enough to pulse `start` mid-flight and to reset the block in the middle of a read-modify-write.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int REG_COST      = 8,
  parameter int MEM_TEST_COST = 12,
  parameter int MEM_RMW_COST  = 16,
  localparam int CNT_W = $clog2(MEM_RMW_COST + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [63:0]      regs_in,
  input  logic [3:0]       flags_in,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack,
  output logic             reg_wr_en,
  output logic [2:0]       reg_wr_sel,
  output logic [7:0]       reg_wr_data,
  output logic             flags_wr,
  output logic [3:0]       flags_out,
  output logic [CNT_W-1:0] cycles,
  output logic             done,
  output logic             unsupported
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_HOLD, S_FIN} st_t;
  localparam logic [1:0] OP_TEST = 2'b01;
  localparam logic [1:0] OP_CLR  = 2'b10;
  localparam logic [1:0] OP_SET  = 2'b11;
  localparam logic [2:0] SEL_MEM = 3'd6;

  st_t             st;
  logic [1:0]      cls_q;
  logic [2:0]      bit_q, sel_q;
  logic [7:0]      val_q;
  logic [3:0]      flg_q;
  logic [15:0]     addr_q;
  logic [CNT_W-1:0] cnt_q, cost_q;
  logic            unsup_q;

  wire       accept = (st == S_IDLE) && start;
  wire       busy   = (st == S_RD) || (st == S_WR) || (st == S_HOLD);
  wire       is_mem = (sel_q == SEL_MEM);
  wire       is_tst = (cls_q == OP_TEST);
  wire [7:0] mask   = 8'd1 << bit_q;
  wire [7:0] res    = (cls_q == OP_CLR) ? (val_q & ~mask) :
                      (cls_q == OP_SET) ? (val_q | mask)  : val_q;

  logic [CNT_W-1:0] cost_d;
  always_comb begin
    if (opcode[2:0] != SEL_MEM)   cost_d = CNT_W'(REG_COST);
    else if (opcode[7:6] == OP_TEST) cost_d = CNT_W'(MEM_TEST_COST);
    else                          cost_d = CNT_W'(MEM_RMW_COST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt_q   <= '0;
      cost_q  <= '0;
      unsup_q <= 1'b0;
      cls_q   <= '0;
      bit_q   <= '0;
      sel_q   <= '0;
      val_q   <= '0;
      flg_q   <= '0;
      addr_q  <= '0;
    end else begin
      unsup_q <= 1'b0;
      if (busy && cnt_q < cost_q) cnt_q <= cnt_q + 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          if (opcode[7:6] == 2'b00) begin
            unsup_q <= 1'b1;
          end else begin
            cls_q  <= opcode[7:6];
            bit_q  <= opcode[5:3];
            sel_q  <= opcode[2:0];
            val_q  <= regs_in[{opcode[2:0], 3'b000} +: 8];
            flg_q  <= flags_in;
            addr_q <= {regs_in[39:32], regs_in[47:40]};
            cost_q <= cost_d;
            cnt_q  <= CNT_W'(1);
            st     <= (opcode[2:0] == SEL_MEM) ? S_RD : S_HOLD;
          end
        end
        S_RD: if (mem_ack) begin
          val_q <= mem_rdata;
          st    <= is_tst ? S_HOLD : S_WR;
        end
        S_WR:   if (mem_ack) st <= S_HOLD;
        S_HOLD: if (cnt_q >= cost_q) st <= S_FIN;
        S_FIN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd      = (st == S_RD);
  assign mem_wr      = (st == S_WR);
  assign mem_addr    = addr_q;
  assign mem_wdata   = res;
  assign done        = (st == S_FIN);
  assign reg_wr_en   = done && !is_mem && !is_tst;
  assign reg_wr_sel  = sel_q;
  assign reg_wr_data = res;
  assign flags_wr    = done && is_tst;
  assign flags_out   = is_tst ? {~val_q[bit_q], 1'b0, 1'b1, flg_q[0]} : flg_q;
  assign cycles      = cost_q;
  assign unsupported = unsup_q;

  a_r3_test_flag_pattern: assert property (@(posedge clk) disable iff (rst)
    flags_wr |-> (flags_out[2:1] == 2'b01));
  a_r4_test_never_writes: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || reg_wr_en) |-> (cls_q != OP_TEST));
  a_r6_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> $past(mem_rd && mem_ack));
  a_r6_same_address: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_rd)) |-> $stable(mem_addr));
  a_r8_request_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ack) |=> mem_rd);
  a_r9_unsupported_quiet: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> !(done || mem_rd || mem_wr || reg_wr_en));
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] regs_in = '0;
  logic [3:0]  flags_in = '0;
  logic        mem_rd, mem_wr, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        reg_wr_en, flags_wr, done, unsupported;
  logic [2:0]  reg_wr_sel;
  logic [7:0]  reg_wr_data;
  logic [3:0]  flags_out;
  logic [4:0]  cycles;

  always #4 clk = ~clk;

  bitop_unit u0 (.clk(clk), .rst(rst), .start(start), .opcode(opcode), .regs_in(regs_in),
    .flags_in(flags_in), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .reg_wr_en(reg_wr_en),
    .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data), .flags_wr(flags_wr),
    .flags_out(flags_out), .cycles(cycles), .done(done), .unsupported(unsupported));

  typedef struct packed {
    logic [7:0]  op;
    logic        unsup;
    logic [4:0]  cost;
    logic [31:0] lat;
    logic        fwr;
    logic [3:0]  flags;
    logic        rwr;
    logic [2:0]  sel;
    logic [7:0]  rdata;
    logic        mem;
    logic [15:0] addr;
    logic [7:0]  mbyte;
    logic [31:0] t0;
    logic [31:0] nrd, nwr, nrw;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [31:0] cyc = 0;
  logic [7:0] mem [256];
  int mem_lat = 0, wcnt = 0;
  logic [31:0] tot_rd = 0, tot_wr = 0, tot_rw = 0;
  logic [31:0] exp_rd = 0, exp_wr = 0, exp_rw = 0;
  logic [15:0] last_addr = '0;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and monitor share one process so counts are ordered
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_rd || mem_wr) begin
      if (wcnt >= mem_lat) begin
        mem_ack = 1'b1;
        last_addr = mem_addr;
        if (mem_wr) begin mem[mem_addr[7:0]] = mem_wdata; tot_wr++; end
        else tot_rd++;
      end else wcnt++;
    end
    if (!rst && reg_wr_en) tot_rw++;
    if (!rst && (done || unsupported)) begin
      if (q.size() == 0) chk(1'b0, "R10 completion with nothing pending", 32'(done), 0);
      else begin
        item_t e;
        e = q.pop_front();
        chk(unsupported == e.unsup, "R9 unsupported flag", 32'(unsupported), 32'(e.unsup));
        chk(cyc - e.t0 == e.lat, (e.mem && mem_lat > 3) ? "R8 completion cycle" : "R7 completion cycle",
            cyc - e.t0, e.lat);
        if (!e.unsup) begin
          chk(cycles == e.cost, "R7 cycles output", 32'(cycles), 32'(e.cost));
          chk(flags_wr == e.fwr, "R3 flags_wr", 32'(flags_wr), 32'(e.fwr));
          if (e.fwr) chk(flags_out == e.flags, "R3 flag values", 32'(flags_out), 32'(e.flags));
          chk(reg_wr_en == e.rwr, "R4/R5 reg_wr_en", 32'(reg_wr_en), 32'(e.rwr));
          if (e.rwr) begin
            chk(reg_wr_sel == e.sel, "R2 reg_wr_sel", 32'(reg_wr_sel), 32'(e.sel));
            chk(reg_wr_data == e.rdata, "R1/R5 reg_wr_data", 32'(reg_wr_data), 32'(e.rdata));
          end
          if (e.mem) begin
            chk(mem[e.addr[7:0]] == e.mbyte, "R6 memory byte", 32'(mem[e.addr[7:0]]), 32'(e.mbyte));
            chk(last_addr == e.addr, "R6 access address", 32'(last_addr), 32'(e.addr));
          end
        end
        chk(tot_rd == e.nrd, "R6 read count", tot_rd, e.nrd);
        chk(tot_wr == e.nwr, "R4/R6 write count", tot_wr, e.nwr);
        chk(tot_rw == e.nrw, "R4/R9 reg write count", tot_rw, e.nrw);
      end
    end
  end

  function automatic logic [63:0] mkregs(input logic [7:0] b, c, d, e, h, l, a);
    return {a, 8'h00, l, h, e, d, c, b};
  endfunction

  task automatic wait_idle();
    int guard = 0;
    while (q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [63:0] rv, input logic [3:0] fl,
                        input int lat, input logic poke);
    item_t e;
    logic [1:0] cls = op[7:6];
    logic [2:0] bi = op[5:3], sl = op[2:0];
    logic [7:0] val, res, mask;
    logic ism = (sl == 3'd6);
    logic [15:0] ad = {rv[39:32], rv[47:40]};
    val  = ism ? mem[ad[7:0]] : rv[8*sl +: 8];
    mask = 8'd1 << bi;
    res  = (cls == 2'b10) ? (val & ~mask) : (cls == 2'b11) ? (val | mask) : val;
    e = '0;
    e.op = op; e.unsup = (cls == 2'b00);
    e.cost = !ism ? 5'd8 : (cls == 2'b01) ? 5'd12 : 5'd16;
    if (e.unsup) e.lat = 0;
    else if (!ism) e.lat = 8;
    else if (cls == 2'b01) e.lat = (lat + 2 > 12) ? lat + 2 : 12;
    else e.lat = (2 * lat + 4 > 16) ? 2 * lat + 4 : 16;
    e.fwr = (cls == 2'b01);
    e.flags = {~val[bi], 1'b0, 1'b1, fl[0]};
    e.rwr = !e.unsup && !ism && cls != 2'b01;
    e.sel = sl; e.rdata = res;
    e.mem = !e.unsup && ism; e.addr = ad;
    e.mbyte = (e.mem && cls != 2'b01) ? res : val;
    if (e.mem) exp_rd++;
    if (e.mem && cls != 2'b01) exp_wr++;
    if (e.rwr) exp_rw++;
    e.nrd = exp_rd; e.nwr = exp_wr; e.nrw = exp_rw;
    mem_lat = lat;
    opcode = op; regs_in = rv; flags_in = fl;
    e.t0 = cyc + 1;
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      opcode = 8'hC7; regs_in = mkregs(0, 0, 0, 0, 0, 0, 8'h00); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    #(8 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr && !reg_wr_en && !unsupported && !flags_wr,
        "R11 reset outputs", {27'd0, done, mem_rd, mem_wr, reg_wr_en, unsupported}, 0);
    rst = 1'b0;
    @(negedge clk);
    // tests on registers
    run_op(8'h48, mkregs(8'h02, 0, 0, 0, 0, 0, 0), 4'b1001, 0, 1'b0);
    run_op(8'h48, mkregs(8'hFD, 0, 0, 0, 0, 0, 0), 4'b0000, 0, 1'b0);
    run_op(8'h7F, mkregs(0, 0, 0, 0, 0, 0, 8'h80), 4'b1110, 0, 1'b0);
    run_op(8'h62, mkregs(0, 0, 8'hEF, 0, 0, 0, 0), 4'b0101, 0, 1'b0);
    // clear and set on registers
    run_op(8'h80, mkregs(8'hFF, 0, 0, 0, 0, 0, 0), 4'b1111, 0, 1'b0);
    run_op(8'hB9, mkregs(0, 8'h40, 0, 0, 0, 0, 0), 4'b0000, 0, 1'b0);
    run_op(8'hFD, mkregs(0, 0, 0, 0, 0, 8'h01, 0), 4'b1010, 0, 1'b0);
    run_op(8'hC3, mkregs(0, 0, 0, 8'h00, 0, 0, 0), 4'b0000, 0, 1'b0);
    run_op(8'hE4, mkregs(0, 0, 0, 0, 8'h10, 0, 0), 4'b0000, 0, 1'b0);
    // memory operand at H:L = 0x1234
    mem[8'h34] = 8'h01;
    run_op(8'h46, mkregs(0, 0, 0, 0, 8'h12, 8'h34, 0), 4'b0001, 0, 1'b0);
    run_op(8'h7E, mkregs(0, 0, 0, 0, 8'h12, 8'h34, 0), 4'b0000, 12, 1'b0);
    run_op(8'h86, mkregs(0, 0, 0, 0, 8'h12, 8'h34, 0), 4'b1111, 0, 1'b0);
    run_op(8'hDE, mkregs(0, 0, 0, 0, 8'h12, 8'h34, 0), 4'b0000, 12, 1'b0);
    run_op(8'hF6, mkregs(0, 0, 0, 0, 8'hAB, 8'h56, 0), 4'b0000, 3, 1'b0);
    run_op(8'h76, mkregs(0, 0, 0, 0, 8'hAB, 8'h56, 0), 4'b0000, 3, 1'b0);
    // unsupported opcodes (R9)
    run_op(8'h37, mkregs(1, 2, 3, 4, 8'h12, 8'h34, 5), 4'b0000, 0, 1'b0);
    run_op(8'h00, mkregs(1, 2, 3, 4, 8'h12, 8'h34, 5), 4'b0000, 0, 1'b0);
    // start while busy is ignored (R10)
    run_op(8'hBE, mkregs(0, 0, 0, 0, 8'h12, 8'h34, 0), 4'b0000, 12, 1'b1);
    run_op(8'h98, mkregs(8'h08, 0, 0, 0, 0, 0, 0), 4'b0000, 0, 1'b1);
    // reset in the middle of a read-modify-write (R11)
    mem_lat = 40;
    opcode = 8'hC6; regs_in = mkregs(0, 0, 0, 0, 8'h12, 8'h66, 0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(mem_rd, "R11 read pending before reset", 32'(mem_rd), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !done, "R11 idle after reset", {29'd0, mem_rd, mem_wr, done}, 0);
    repeat (20) @(negedge clk);
    chk(tot_wr == exp_wr, "R11 no write after reset", tot_wr, exp_wr);
    run_op(8'hC6, mkregs(0, 0, 0, 0, 8'h12, 8'h66, 0), 4'b0000, 0, 1'b0);
    chk(q.size() == 0, "R10 scoreboard drained", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule